// File: doc/BRIEF.md
# Byte and Halfword Swap Unit

A purely combinational rearrangement unit for a 32-bit datapath. A 2-bit operation code picks one of three byte orderings: each 16-bit half has its two bytes swapped, the whole word has its byte order reversed, or the two halfwords trade places. The fourth code passes the operand through unchanged.

Alongside the rearranged word, the unit produces four condition flags: zero, sign, carry and overflow. The surrounding pipeline may write these flags into its status register. Overflow is always cleared. Carry has a separate meaning for each swap mode, and in each case it reports zero bytes or zero halfwords in the result. This lets software test for a string terminator in the same step that changes endianness.

Top module: `bswap_unit`

## Requirements
- R1: With op code 2'b00, the result is {src[23:16], src[31:24], src[7:0], src[15:8]}, meaning the bytes inside each halfword trade places.
- R2: With op code 2'b01, the result is {src[7:0], src[15:8], src[23:16], src[31:24]}, a full reversal of the four bytes.
- R3: With op code 2'b10, the result is {src[15:0], src[31:16]}.
- R4: With op code 2'b11, the result equals the source and all four flags are 0.
- R5: For op codes 2'b00 to 2'b10, zero_o is 1 exactly when the 32-bit result is 0.
- R6: For op codes 2'b00 to 2'b10, sign_o equals bit 31 of the result.
- R7: ovf_o is 0 for every op code and operand.
- R8: With op code 2'b01, carry_o is 1 exactly when at least one of the four result bytes is 0.
- R9: With op code 2'b10, carry_o is 1 exactly when result bits [15:0] are 0 or result bits [31:16] are 0.
- R10: With op code 2'b00, carry_o is 1 exactly when result bits [7:0] are 0. Zero bytes elsewhere in the result do not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 32 | Operand word |
| op_i | input | 2 | Operation code: 00 halfword byte swap, 01 word byte reverse, 10 halfword exchange, 11 pass |
| res_o | output | 32 | Rearranged word |
| zero_o | output | 1 | Result is all zero |
| sign_o | output | 1 | Copy of result bit 31 |
| carry_o | output | 1 | Mode-specific zero-byte or zero-halfword indication |
| ovf_o | output | 1 | Overflow flag, always 0 |

## Verification
The bench builds the unit with the default lane width BYTE_W = 8, which gives the 32-bit word the requirements describe. That width keeps every byte lane small enough to zero individually. The bench can therefore place a single zero byte in each lane and show that the carry flag follows a different lane set in each mode. Operands with bit 7 or bit 15 set move into bit 31 under the different orderings, and this drives the sign flag from each source position.

// File: rtl/bswap_pkg.sv
package bswap_pkg;

  typedef enum logic [1:0] {
    OP_HW_BSWAP = 2'b00,
    OP_W_BREV   = 2'b01,
    OP_H_XCHG   = 2'b10,
    OP_PASS     = 2'b11
  } swap_op_e;

  typedef struct packed {
    logic zero;
    logic sign;
    logic carry;
    logic ovf;
  } swap_flags_t;

endpackage

// File: rtl/bswap_lane_mux.sv
module bswap_lane_mux
  import bswap_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 4
) (
  input  logic [NBYTES*BYTE_W-1:0] src_i,
  input  swap_op_e                 op_i,
  output logic [NBYTES*BYTE_W-1:0] res_o
);

  localparam int HALF_B = NBYTES / 2;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    // source lane for each ordering
    localparam int HS_IDX = i ^ 1;
    localparam int WR_IDX = NBYTES - 1 - i;
    localparam int HX_IDX = i ^ HALF_B;

    always_comb begin
      unique case (op_i)
        OP_HW_BSWAP: res_o[i*BYTE_W +: BYTE_W] = src_i[HS_IDX*BYTE_W +: BYTE_W];
        OP_W_BREV:   res_o[i*BYTE_W +: BYTE_W] = src_i[WR_IDX*BYTE_W +: BYTE_W];
        OP_H_XCHG:   res_o[i*BYTE_W +: BYTE_W] = src_i[HX_IDX*BYTE_W +: BYTE_W];
        default:     res_o[i*BYTE_W +: BYTE_W] = src_i[i*BYTE_W +: BYTE_W];
      endcase
    end
  end

endmodule

// File: rtl/bswap_flag_gen.sv
module bswap_flag_gen
  import bswap_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 4
) (
  input  logic [NBYTES*BYTE_W-1:0] res_i,
  input  swap_op_e                 op_i,
  output swap_flags_t              flags_o
);

  localparam int WORD_W = NBYTES * BYTE_W;
  localparam int HALF_W = WORD_W / 2;
  localparam int HALF_B = NBYTES / 2;

  logic [NBYTES-1:0] byte_nz;
  logic [1:0]        half_nz;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte_nz
    assign byte_nz[i] = |res_i[i*BYTE_W +: BYTE_W];
  end

  // halfword non-zero built from the byte detectors
  for (genvar h = 0; h < 2; h++) begin : g_half_nz
    assign half_nz[h] = |byte_nz[h*HALF_B +: HALF_B];
  end

  logic any_nz;
  assign any_nz = |half_nz;

  always_comb begin
    flags_o = '0;
    if (op_i != OP_PASS) begin
      flags_o.zero = ~any_nz;
      flags_o.sign = res_i[WORD_W-1];
    end
    unique case (op_i)
      OP_HW_BSWAP: flags_o.carry = ~byte_nz[0];
      OP_W_BREV:   flags_o.carry = ~&byte_nz;
      OP_H_XCHG:   flags_o.carry = ~&half_nz;
      default:     flags_o.carry = 1'b0;
    endcase
  end

  logic unused_w;
  assign unused_w = ^HALF_W;

endmodule

// File: rtl/bswap_unit.sv
module bswap_unit
  import bswap_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [4*BYTE_W-1:0] src_i,
  input  logic [1:0]          op_i,
  output logic [4*BYTE_W-1:0] res_o,
  output logic                zero_o,
  output logic                sign_o,
  output logic                carry_o,
  output logic                ovf_o
);

  localparam int NBYTES = 4;
  localparam int WORD_W = NBYTES * BYTE_W;

  swap_op_e              op;
  logic [WORD_W-1:0]     res;
  swap_flags_t           flags;

  assign op = swap_op_e'(op_i);

  bswap_lane_mux #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_mux (
    .src_i (src_i),
    .op_i  (op),
    .res_o (res)
  );

  bswap_flag_gen #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_flags (
    .res_i   (res),
    .op_i    (op),
    .flags_o (flags)
  );

  assign res_o   = res;
  assign zero_o  = flags.zero;
  assign sign_o  = flags.sign;
  assign carry_o = flags.carry;
  assign ovf_o   = flags.ovf;

  always_comb begin
    if (!$isunknown({src_i, op_i})) begin
      a_r7_no_overflow: assert (!ovf_o);
      // reorderings move bytes, never create or drop bits (R1, R2, R3)
      a_r1_bit_count: assert ($countones(res_o) == $countones(src_i));
      a_r4_pass_quiet: assert (op_i != 2'b11 ||
                               (res_o == src_i && !zero_o && !sign_o && !carry_o));
      // an all-zero result contains zero bytes in every mode (R5, R8, R9, R10)
      a_r5_zero_has_carry: assert (op_i == 2'b11 || !zero_o || carry_o);
      a_r6_sign_lane: assert (op_i == 2'b11 || sign_o == res_o[WORD_W-1]);
    end
  end

endmodule

// File: tb/sim_bswap_unit.sv
module sim_bswap_unit;

  logic        clk;
  logic        rst_ni;
  logic [31:0] src;
  logic [1:0]  op;
  logic [31:0] res;
  logic        zf, sf, cf, vf;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  bswap_unit #(.BYTE_W(8)) u0 (
    .src_i   (src),
    .op_i    (op),
    .res_o   (res),
    .zero_o  (zf),
    .sign_o  (sf),
    .carry_o (cf),
    .ovf_o   (vf)
  );

  function automatic logic [31:0] model_res(input logic [31:0] s, input logic [1:0] o);
    case (o)
      2'b00:   return {s[23:16], s[31:24], s[7:0], s[15:8]};
      2'b01:   return {s[7:0], s[15:8], s[23:16], s[31:24]};
      2'b10:   return {s[15:0], s[31:16]};
      default: return s;
    endcase
  endfunction

  function automatic logic model_carry(input logic [31:0] r, input logic [1:0] o);
    case (o)
      2'b00:   return r[7:0] == 8'h00;
      2'b01:   return r[7:0] == 0 || r[15:8] == 0 || r[23:16] == 0 || r[31:24] == 0;
      2'b10:   return r[15:0] == 16'h0 || r[31:16] == 16'h0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns later
  task automatic apply(input logic [31:0] s, input logic [1:0] o, input string req);
    logic [31:0] er;
    string creq;
    @(negedge clk);
    src = s;
    op  = o;
    #1;
    er = model_res(s, o);
    check(req, "res", res, er);
    case (o)
      2'b00: creq = "R10";
      2'b01: creq = "R8";
      2'b10: creq = "R9";
      default: creq = "R4";
    endcase
    check(creq, "carry", {31'b0, cf}, {31'b0, model_carry(er, o)});
    check("R7", "ovf", {31'b0, vf}, 32'b0);
    if (o == 2'b11) begin
      check("R4", "zero", {31'b0, zf}, 32'b0);
      check("R4", "sign", {31'b0, sf}, 32'b0);
    end else begin
      check("R5", "zero", {31'b0, zf}, {31'b0, er == 32'b0});
      check("R6", "sign", {31'b0, sf}, {31'b0, er[31]});
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    #1;
    check("R4", "reset res", res, 32'h0);
    check("R4", "reset flags", {28'b0, zf, sf, cf, vf}, 32'h0);
  endtask

  task automatic t_hw_bswap;  // R1, R10
    apply(32'h1122_3344, 2'b00, "R1");
    apply(32'h80FF_0001, 2'b00, "R1");
    apply(32'hA5A5_00C3, 2'b00, "R10"); // result byte 0 is zero
    apply(32'h0000_C300, 2'b00, "R10"); // zero bytes above byte 0 only
    apply(32'h0000_0000, 2'b00, "R5");
  endtask

  task automatic t_w_brev;  // R2, R8
    apply(32'h1122_3344, 2'b01, "R2");
    apply(32'h0000_0080, 2'b01, "R6");
    apply(32'h0011_2233, 2'b01, "R8");
    apply(32'h1100_2233, 2'b01, "R8");
    apply(32'h1122_0033, 2'b01, "R8");
    apply(32'h1122_3300, 2'b01, "R8");
    apply(32'h0000_0000, 2'b01, "R5");
  endtask

  task automatic t_h_xchg;  // R3, R9
    apply(32'hDEAD_BEEF, 2'b10, "R3");
    apply(32'h0000_8001, 2'b10, "R9");
    apply(32'h1234_0000, 2'b10, "R9");
    apply(32'h0100_0001, 2'b10, "R9");
    apply(32'h0000_0000, 2'b10, "R5");
  endtask

  task automatic t_pass;  // R4
    apply(32'hFFFF_FFFF, 2'b11, "R4");
    apply(32'h0000_0000, 2'b11, "R4");
    apply(32'h8000_0100, 2'b11, "R4");
  endtask

  initial begin
    rst_ni = 1'b0;
    src = '0;
    op  = 2'b11;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_hw_bswap();
    t_w_brev();
    t_h_xchg();
    t_pass();
    for (int k = 0; k < 64; k++) begin
      logic [31:0] v;
      v = 32'h9E37_79B9 * (k + 1);
      if (k % 5 == 0) v[15:8] = 8'h00;
      apply(v, k[1:0], "R5");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule